// File: doc/BRIEF.md
# Parking Bus Arbiter

This block decides which of N bus masters may drive a shared bus. Each master has a request line and a one-cycle release pulse, and each gets a grant line back. Only one grant is ever high. The owner keeps its grant until it releases or until the arbiter withdraws it. While the owner is working, the arbiter is already picking its successor, so the grant moves on the clock edge right after a release and no cycle is spent re-arbitrating.

When a master releases and nobody else is waiting, its grant stays where it is: the master is parked. A parked master can start a new transfer just by raising its request again, with no arbitration round trip. Priority rotates so that the master that just held the bus drops to the bottom. A tenure counter withdraws the grant from a busy owner that keeps the bus for too long while others wait. Together these bound the wait of every requester.

Top module: `park_arb`

## Requirements
- R1: After reset no grant is asserted and the parking owner is master 0. The first grant therefore scans masters in the order 1, 2, …, N-1, 0.
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: While no grant is held and some master requests, the next cycle grants exactly one requesting master.
- R4: The winner is the first requesting master in circular order starting at owner+1 (index wrapping from N-1 to 0). The current owner is excluded, so it has the lowest priority.
- R5: A busy owner is released by a pulse on its bit of `done_i`. If another master is requesting in that cycle, the grant moves to the winner on the next cycle with no idle cycle in between.
- R6: If the owner releases while no other master requests, its grant stays asserted (parked). If the parked owner then raises its request, it keeps the grant and becomes busy again.
- R7: A parked owner whose request is low loses the grant on the next cycle after any other master requests.
- R8: A `done_i` pulse from a master that does not hold the grant has no effect on the grant.
- R9: A busy owner that has not released during HOLD_MAX consecutive cycles in which another master requests loses the grant. The grant moves to the winner after the HOLD_MAX-th such cycle.
- R10: The grant changes only on a cycle after the owner released, was parked, or was preempted. Otherwise it holds.
- R11: A master that requests continuously is granted within N·(HOLD_MAX+2) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N | Per-master bus request |
| done_i | input | N | Per-master one-cycle release pulse |
| gnt_o | output | N | Per-master grant, at most one high |

## Verification
The bench first targets the wrap of the rotating priority past index N-1. An arbiter with a fixed order would give the bus back to low indices there.

It then drives a release pulse from a master that does not own the bus. A design that failed to qualify the pulse with ownership would hand the bus away early.

It holds a busy owner under contention for exactly HOLD_MAX cycles and checks the edge on which the grant moves. An off-by-one in the tenure counter shows up as a grant that moves a cycle early or a cycle late.

It also covers parking in both directions: the parked owner resuming, and another master taking the bus from a parked owner. A design without parking would drop the grant, and one that tracked ownership wrongly would keep a parked owner on the bus while others wait.

// File: rtl/park_arb_pkg.sv
package park_arb_pkg;

    // Ownership state of the grant holder
    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,  // no grant asserted (after reset only)
        OWN_BUSY   = 2'd1,  // owner is using the bus
        OWN_PARKED = 2'd2   // owner released, grant left in place
    } own_st_e;

    // Per-cycle decision bundle
    typedef struct packed {
        logic pend;    // some non-owner is requesting
        logic rel;     // busy owner pulsed its release
        logic take;    // grant moves to the picked winner
        logic resume;  // parked owner starts another transfer
    } arb_dec_t;

    function automatic logic one_hot_ok(input logic [31:0] v);
        return $countones(v) <= 1;
    endfunction

endpackage

// File: rtl/park_arb_pick.sv
module park_arb_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] base,
    output logic [IW-1:0] win,
    output logic          any
);
    // Circular search starting one past the base index, base itself last
    always_comb begin
        win = base;
        any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(base) + k;
            if (idx >= N) idx = idx - N;
            if (!any && cand[idx]) begin
                any = 1'b1;
                win = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/park_arb_tenure.sv
module park_arb_tenure #(
    parameter int HOLD_MAX = 8,
    localparam int CW = $clog2(HOLD_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expire
);
    logic [CW-1:0] cnt;

    assign expire = tick && (cnt == CW'(HOLD_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/park_arb.sv
module park_arb #(
    parameter int N        = 4,
    parameter int HOLD_MAX = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] done_i,
    output logic [N-1:0] gnt_o
);
    import park_arb_pkg::*;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    own_st_e       st;
    logic [IW-1:0] owner;
    logic [N-1:0]  own_oh;
    logic [N-1:0]  cand;
    logic [IW-1:0] win;
    logic          any;
    logic          expire;
    logic          busy;
    logic          parked;
    arb_dec_t      dec;

    assign own_oh = N'(1) << owner;
    assign busy   = (st == OWN_BUSY);
    assign parked = (st == OWN_PARKED);
    assign cand   = (st == OWN_NONE) ? req_i : (req_i & ~own_oh);

    park_arb_pick #(.N(N)) u_pick (
        .cand (cand),
        .base (owner),
        .win  (win),
        .any  (any)
    );

    always_comb begin
        dec.pend   = any;
        dec.rel    = busy && done_i[owner];
        dec.resume = parked && req_i[owner];
        dec.take   = ((st == OWN_NONE) && any)
                   || (dec.rel && any)
                   || (parked && any && !req_i[owner])
                   || expire;
    end

    park_arb_tenure #(.HOLD_MAX(HOLD_MAX)) u_tenure (
        .clk    (clk),
        .rst    (rst),
        .clear  (dec.take || !dec.pend || !busy),
        .tick   (busy && dec.pend && !dec.rel),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= OWN_NONE;
            owner <= '0;
        end else if (dec.take) begin
            st    <= OWN_BUSY;
            owner <= win;
        end else if (dec.rel) begin
            st    <= OWN_PARKED;
        end else if (dec.resume) begin
            st    <= OWN_BUSY;
        end
    end

    assign gnt_o = (st == OWN_NONE) ? '0 : own_oh;
endmodule

// File: rtl/park_arb_chk.sv
module park_arb_chk #(
    parameter int N        = 4,
    parameter int HOLD_MAX = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req_i,
    input logic [N-1:0] done_i,
    input logic [N-1:0] gnt_o,
    input logic         parked,
    input logic         expire
);
    logic [N-1:0] prev_gnt;
    int           wcnt;
    logic         contend;

    assign contend = (gnt_o != '0) && ((req_i & ~gnt_o) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_gnt <= '0;
            wcnt     <= 0;
        end else begin
            prev_gnt <= gnt_o;
            if (!contend)              wcnt <= 0;
            else if (gnt_o == prev_gnt) wcnt <= wcnt + 1;
            else                       wcnt <= 1;
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gnt_o == '0));

    p_single_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    p_grant_to_requester_r3: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != $past(gnt_o)) |-> ((gnt_o & $past(req_i)) != '0));

    p_park_holds_r6: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o != '0) && ((req_i & ~gnt_o) == '0)) |=> $stable(gnt_o));

    p_change_cause_r10: assert property (@(posedge clk) disable iff (rst)
        (($past(gnt_o) != '0) && (gnt_o != $past(gnt_o)))
        |-> ($past((done_i & gnt_o) != '0) || $past(parked) || $past(expire)));

    p_tenure_bound_r9: assert property (@(posedge clk) disable iff (rst)
        wcnt <= HOLD_MAX + 2);
endmodule

bind park_arb park_arb_chk #(.N(N), .HOLD_MAX(HOLD_MAX)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .done_i (done_i),
    .gnt_o  (gnt_o),
    .parked (parked),
    .expire (expire)
);

// File: tb/sim_park_arb.sv
module sim_park_arb;
    localparam int N        = 4;
    localparam int HOLD_MAX = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req  = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] gnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state: 0 none, 1 busy, 2 parked
    int m_st = 0;
    int m_o  = 0;
    int m_c  = 0;
    int wait_cnt [N];
    int max_wait = 0;

    always #10 clk = ~clk;  // 50 MHz

    park_arb #(.N(N), .HOLD_MAX(HOLD_MAX)) u0 (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .done_i (done),
        .gnt_o  (gnt)
    );

    function automatic logic [N-1:0] exp_gnt();
        return (m_st == 0) ? '0 : (N'(1) << m_o);
    endfunction

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
        end
    endtask

    // Reference update from the requirements, applied at each clock edge
    task automatic model(input logic [N-1:0] r, input logic [N-1:0] d);
        logic [N-1:0] c;
        int  w;
        bit  pend, rel, take, expire;
        c = (m_st == 0) ? r : (r & ~(N'(1) << m_o));
        w = -1;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (m_o + k) % N;
            if (w < 0 && c[idx]) w = idx;
        end
        pend   = (w >= 0);
        rel    = (m_st == 1) && d[m_o];
        expire = (m_st == 1) && pend && !rel && (m_c == HOLD_MAX - 1);
        take   = ((m_st == 0) && pend) || (rel && pend)
              || ((m_st == 2) && pend && !r[m_o]) || expire;
        if (take) begin
            m_st = 1; m_o = w; m_c = 0;
        end else if (rel) begin
            m_st = 2; m_c = 0;
        end else if (m_st == 2) begin
            if (r[m_o]) m_st = 1;
            m_c = 0;
        end else if (m_st == 1) begin
            m_c = pend ? m_c + 1 : 0;
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] d, input string tag);
        req  = r;
        done = d;
        model(r, d);
        @(negedge clk);
        check(gnt, exp_gnt(), tag);
        for (int i = 0; i < N; i++) begin
            if (req[i] && !gnt[i]) wait_cnt[i]++;
            else wait_cnt[i] = 0;
            if (wait_cnt[i] > max_wait) max_wait = wait_cnt[i];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < N; i++) wait_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(gnt, 4'b0000, "R1 reset");

        step(4'b0000, 4'b0000, "R1");
        check(gnt, 4'b0000, "R1 idle");
        step(4'b1111, 4'b0000, "R3");
        check(gnt, 4'b0010, "R1 first scan from 1");
        step(4'b1101, 4'b0010, "R5");
        check(gnt, 4'b0100, "R5 handover");
        step(4'b0000, 4'b0100, "R6");
        check(gnt, 4'b0100, "R6 park");
        step(4'b0100, 4'b0000, "R6");
        check(gnt, 4'b0100, "R6 resume");
        step(4'b0001, 4'b1000, "R8");
        check(gnt, 4'b0100, "R8 foreign release");
        for (int k = 2; k < HOLD_MAX; k++) begin
            step(4'b0001, 4'b0000, "R9");
            check(gnt, 4'b0100, "R9 still held");
        end
        step(4'b0001, 4'b0000, "R9");
        check(gnt, 4'b0001, "R9 preempt");
        step(4'b0001, 4'b0001, "R6");
        check(gnt, 4'b0001, "R6 park again");
        step(4'b1000, 4'b0000, "R7");
        check(gnt, 4'b1000, "R7 parked loses");
        step(4'b0111, 4'b1000, "R4");
        check(gnt, 4'b0001, "R4 wrap");
        step(4'b0110, 4'b0001, "R4");
        check(gnt, 4'b0010, "R4 rotate");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] r, d;
            r = N'($urandom);
            d = N'($urandom) & N'($urandom);
            step(r, d, "R10");
            n_chk++;
            if ($countones(gnt) > 1) begin
                n_bad++;
                $display("FAIL R2: gnt=%b expected at most one bit", gnt);
            end
        end
        // all requesting, sparse releases: fairness bound
        max_wait = 0;
        for (int i = 0; i < N; i++) wait_cnt[i] = 0;
        for (int n = 0; n < 2000; n++) begin
            logic [N-1:0] d;
            d = (($urandom % 16) == 0) ? N'($urandom) : '0;
            step(4'b1111, d, "R11");
        end
        n_chk++;
        if (max_wait > N * (HOLD_MAX + 2)) begin
            n_bad++;
            $display("FAIL R11: max wait %0d expected <= %0d", max_wait, N * (HOLD_MAX + 2));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule